// File: doc/BRIEF.md
# Programmable Interval Timer Accumulator

This block marks the passage of a programmed time interval by repeated addition. On every clock edge it adds a stored step value to a wrapping accumulator. When the sum runs past full scale, the block signals the wrap on an active-low, registered pulse output, one clock wide. With a step of `D` in a `W`-bit accumulator, the pulse recurs every 2^W / D clocks on average. A step that divides 2^W gives an exact period.

The step is loaded through an active-low initialize input, which is first registered on the clock. While the registered initialize is active, the step register captures the data bus, the accumulator is held at zero and no pulse is raised. Timing therefore restarts from a clean phase once initialize is released. At any other time the data bus is ignored.

Top module: `prog_timer_acc`

## Requirements
- R1: A synchronous active-high `rst` drives `tick_n` high, clears the accumulator and clears the step register. After reset, and with no initialize, `tick_n` stays high.
- R2: `init_n` is active low and acts one clock late. The edge that samples `init_n` low sets the internal initialize flag. The next edge loads `step_in` into the step register.
- R3: On any edge where the registered initialize flag is set, the accumulator is set to zero and `tick_n` is driven high. This holds even on an edge where the accumulator would otherwise have wrapped.
- R4: Call the first edge after the one that loaded step `D` edge n=1. After edge n, `tick_n` is low if and only if floor(n*D / 2^W) > floor((n-1)*D / 2^W). Otherwise it is high, so each wrap gives exactly one low clock.
- R5: A step of zero never drives `tick_n` low.
- R6: Changes on `step_in` while the registered initialize flag is clear have no effect on the pulse timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| init_n | input | 1 | Initialize, active low, registered before use |
| step_in | input | ACC_W | Step value captured during initialize |
| tick_n | output | 1 | Registered wrap pulse, active low |

## Verification
Two events can fall on the same clock edge: an accumulator wrap and a registered initialize. The bench provokes this with a step of 64 in an 8-bit accumulator. It lowers `init_n` so that the flag registers on the edge before the fourth accumulation, the edge where the wrap is due. The pulse must stay high through that edge and while initialize is held, because the clear wins. Every step value from 0 to 255 is also swept for 260 clocks against the floor-division rule. During each sweep `step_in` is held at a different value, so any leak of the bus into the timing shows up.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
  localparam int unsigned TACC_DEF_W = 32;
endpackage

// File: rtl/tacc_init_sync.sv
module tacc_init_sync (
  input  logic clk,
  input  logic rst,
  input  logic init_n,
  output logic init_q
);
  // R2: the active-low input is captured as an active-high flag
  always_ff @(posedge clk) begin
    if (rst) init_q <= 1'b0;
    else     init_q <= ~init_n;
  end
endmodule

// File: rtl/tacc_step_reg.sv
module tacc_step_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R6: without the registered load flag the step never moves
  p_step_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/tacc_core.sv
module tacc_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic [W-1:0] step,
  output logic         tick_n
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  acc_q;
  logic [SW-1:0] sum;

  always_comb begin
    sum = {1'b0, acc_q} + {1'b0, step};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      tick_n <= 1'b1;
    end else if (clear) begin
      acc_q  <= '0;
      tick_n <= 1'b1;
    end else begin
      acc_q  <= sum[W-1:0];
      tick_n <= ~sum[W];
    end
  end

  // R3: a registered initialize leaves zero phase and no pulse
  p_clear_phase_r3: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc_q == '0) && tick_n);

  // R5: a zero step cannot wrap
  p_zero_step_r5: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> tick_n);

  // R4: after a wrap the residue is smaller than the step that caused it
  p_wrap_residue_r4: assert property (@(posedge clk) disable iff (rst)
    !tick_n |-> (acc_q < step));
endmodule

// File: rtl/prog_timer_acc.sv
module prog_timer_acc #(
  parameter int unsigned ACC_W = tacc_pkg::TACC_DEF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_n,
  input  logic [ACC_W-1:0] step_in,
  output logic             tick_n
);
  logic             init_q;
  logic [ACC_W-1:0] step_q;

  tacc_init_sync u_sync (
    .clk   (clk),
    .rst   (rst),
    .init_n(init_n),
    .init_q(init_q)
  );

  tacc_step_reg #(.W(ACC_W)) u_step (
    .clk (clk),
    .rst (rst),
    .load(init_q),
    .d   (step_in),
    .q   (step_q)
  );

  tacc_core #(.W(ACC_W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .clear (init_q),
    .step  (step_q),
    .tick_n(tick_n)
  );
endmodule

// File: tb/prog_timer_acc_test.sv
module prog_timer_acc_test;
  localparam int unsigned W = 8;
  localparam int FULL = 1 << W;
  localparam int RUN  = 260;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         init_n = 1'b1;
  logic [W-1:0] step_in = '0;
  logic         tick_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  prog_timer_acc #(.ACC_W(W)) uut (
    .clk    (clk),
    .rst    (rst),
    .init_n (init_n),
    .step_in(step_in),
    .tick_n (tick_n)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s tick_n=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Load step d; return at the negedge after the loading edge.
  task automatic load_step(input int d);
    @(negedge clk); init_n = 1'b0; step_in = W'(d);
    @(negedge clk); init_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", tick_n, 1'b1);
    rst = 1'b0;
    // R1: cleared step gives no pulse without initialize
    begin
      logic seen_low = 1'b0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (tick_n !== 1'b1) seen_low = 1'b1;
      end
      check("R1 idle after reset", seen_low, 1'b0);
    end

    // R4 R5 R6 R2: sweep every step value
    for (int d = 0; d < FULL; d++) begin
      int first_bad = -1;
      logic act_bad = 1'b0, exp_bad = 1'b0;
      load_step(d);
      check("R3 clean restart", tick_n, 1'b1);
      step_in = ~W'(d); // R6: bus noise must be ignored
      for (int n = 1; n <= RUN; n++) begin
        logic e;
        @(negedge clk);
        e = (((n * d) / FULL) > (((n - 1) * d) / FULL)) ? 1'b0 : 1'b1;
        if (tick_n !== e && first_bad < 0) begin
          first_bad = n; act_bad = tick_n; exp_bad = e;
        end
      end
      if (d == 0) check("R5 zero step", (first_bad < 0) ? 1'b1 : act_bad, 1'b1);
      else        check("R4/R6 sweep", (first_bad < 0) ? 1'b0 : act_bad,
                        (first_bad < 0) ? 1'b0 : exp_bad);
    end

    // R3: collision of wrap and initialize, step 64
    load_step(64);
    step_in = 8'd3;
    @(negedge clk); // n=1 acc=64
    @(negedge clk); // n=2 acc=128
    init_n = 1'b0;  // flag set at edge n=3
    @(negedge clk); // n=3 acc=192
    check("R3 before collision", tick_n, 1'b1);
    @(negedge clk); // n=4 would wrap, clear wins
    check("R3 collision suppressed", tick_n, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R3 held init", tick_n, 1'b1);
    end
    init_n = 1'b1;
    @(negedge clk); // last clearing edge, step 3 loaded
    // R2: new step 3 -> first wrap at n=86
    for (int n = 1; n <= 86; n++) begin
      @(negedge clk);
      if (n == 85) check("R2 new step no early wrap", tick_n, 1'b1);
      if (n == 86) check("R2 new step wrap", tick_n, 1'b0);
    end

    // R1: reset mid-run
    load_step(128);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset mid-run", tick_n, 1'b1);
    begin
      logic seen_low = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (tick_n !== 1'b1) seen_low = 1'b1;
      end
      check("R1 step cleared", seen_low, 1'b0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule